// File: doc/BRIEF.md
# Register-Amount Barrel Shifter with Carry Flag

This block shifts or rotates a data word by an amount taken from a register operand and reports the bit shifted out as a carry flag. Four operations are offered: left logical, right logical, right arithmetic and right rotate. Only the lowest byte of the amount register is used. Because that byte can reach 255, the result and the carry are defined for amounts at and beyond the word width, not only inside it.

Some operations leave the carry alone. In that case a qualifier output is low and the consumer keeps the carry it already holds. Inputs are sampled on every clock edge. The result, the carry and the qualifier are registered and appear one cycle later, so a new operation can be issued every cycle.

Top module: `regshift_top`

## Requirements
- R1: The effective amount n is bits [7:0] of `amt_i`. Bits [31:8] have no effect on any output.
- R2: For every operation, n = 0 yields `res_o` equal to the input word, `carry_vld_o` = 0 and `carry_o` = 0.
- R3: Operation code 2'b00 is a left logical shift. For 1 ≤ n ≤ 31 the result is the word shifted left and carry = word bit (32−n). For n = 32 the result is 0 and carry = bit 0. For n > 32 both result and carry are 0.
- R4: Operation code 2'b01 is a right logical shift. For 1 ≤ n ≤ 31 the carry is word bit (n−1). For n = 32 the result is 0 and carry = bit 31. For n > 32 both result and carry are 0.
- R5: Operation code 2'b10 is a right arithmetic shift. For 1 ≤ n ≤ 31 the result is sign-extended and carry = bit (n−1). For n ≥ 32 every result bit equals bit 31, and carry = bit 31.
- R6: Operation code 2'b11 is a right rotate by r = n mod 32. When r ≠ 0, the result is the word rotated right by r and carry = bit (r−1).
- R7: For a right rotate with r = 0 and n ≠ 0, the result equals the input word and carry = bit 31.
- R8: Whenever n ≠ 0, `carry_vld_o` is 1.
- R9: Outputs are registered with one cycle of latency. While `rst_n` is low, all outputs are 0.
- R10: `carry_o` is 0 whenever `carry_vld_o` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| src_i | input | 32 | Word to shift or rotate |
| amt_i | input | 32 | Amount register; only the low byte is used |
| kind_i | input | 2 | Operation select: 00 left logical, 01 right logical, 10 right arithmetic, 11 right rotate |
| res_o | output | 32 | Shifted or rotated word |
| carry_o | output | 1 | Last bit shifted out |
| carry_vld_o | output | 1 | High when `carry_o` replaces the held carry |

## Verification
Two behaviours produce an unchanged word: the pass-through for a zero amount and a rotate by a nonzero multiple of 32. They differ only in the carry qualifier and the carry value. The bench issues them back to back on the same word, with bit 31 set, in consecutive cycles. It judges each cycle by the qualifier and the carry: a zero amount must give qualifier 0 and carry 0, and a rotate by 64 must give qualifier 1 and carry equal to bit 31. A second pair places an amount with a zero low byte and nonzero upper bits next to a rotate by 32, so that the upper bits cannot be mistaken for a real amount.

// File: rtl/regshift_pkg.sv
package regshift_pkg;

    typedef enum logic [1:0] {
        OP_LSL = 2'b00,
        OP_LSR = 2'b01,
        OP_ASR = 2'b10,
        OP_ROR = 2'b11
    } shift_op_e;

endpackage

// File: rtl/regshift_decode.sv
module regshift_decode #(
    parameter int DATA_W    = 32,
    parameter int AMT_REG_W = 32,
    parameter int AMT_SEL_W = 8,
    localparam int SH_W     = $clog2(DATA_W)
) (
    input  logic [AMT_REG_W-1:0] amt_reg,
    output logic [SH_W-1:0]      sh_low,
    output logic                 amt_zero,
    output logic                 amt_below_w,
    output logic                 amt_at_w,
    output logic                 residue_zero
);

    localparam logic [AMT_SEL_W:0] W_CMP = (AMT_SEL_W+1)'(DATA_W);

    logic [AMT_SEL_W-1:0] amt_byte;

    always_comb begin
        amt_byte     = amt_reg[AMT_SEL_W-1:0];
        sh_low       = amt_byte[SH_W-1:0];
        amt_zero     = (amt_byte == '0);
        amt_below_w  = ({1'b0, amt_byte} < W_CMP);
        amt_at_w     = ({1'b0, amt_byte} == W_CMP);
        residue_zero = (sh_low == '0);
    end

endmodule

// File: rtl/regshift_barrel.sv
module regshift_barrel
    import regshift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SH_W-1:0]   sh,
    input  shift_op_e         op,
    output logic [DATA_W-1:0] shifted
);

    logic [DATA_W-1:0] rot_stage [SH_W+1];

    assign rot_stage[0] = src;

    for (genvar k = 0; k < SH_W; k++) begin : g_rot
        localparam int STEP = 1 << k;
        assign rot_stage[k+1] = sh[k]
            ? {rot_stage[k][STEP-1:0], rot_stage[k][DATA_W-1:STEP]}
            : rot_stage[k];
    end

    always_comb begin
        unique case (op)
            OP_LSL:  shifted = src << sh;
            OP_LSR:  shifted = src >> sh;
            OP_ASR:  shifted = DATA_W'($signed(src) >>> sh);
            default: shifted = rot_stage[SH_W];
        endcase
    end

endmodule

// File: rtl/regshift_carry.sv
module regshift_carry
    import regshift_pkg::*;
#(
    parameter int DATA_W = 32,
    localparam int SH_W  = $clog2(DATA_W)
) (
    input  logic [DATA_W-1:0] src,
    input  logic [SH_W-1:0]   sh,
    input  shift_op_e         op,
    input  logic              amt_zero,
    input  logic              amt_below_w,
    input  logic              amt_at_w,
    input  logic              residue_zero,
    output logic              carry,
    output logic              carry_vld
);

    logic [SH_W-1:0] up_idx;
    logic [SH_W-1:0] dn_idx;
    logic            msb;

    always_comb begin
        up_idx    = SH_W'(DATA_W) - sh;
        dn_idx    = sh - SH_W'(1);
        msb       = src[DATA_W-1];
        carry     = 1'b0;
        carry_vld = !amt_zero;
        if (!amt_zero) begin
            unique case (op)
                OP_LSL: begin
                    if (amt_below_w)   carry = src[up_idx];
                    else if (amt_at_w) carry = src[0];
                    else               carry = 1'b0;
                end
                OP_LSR: begin
                    if (amt_below_w)   carry = src[dn_idx];
                    else if (amt_at_w) carry = msb;
                    else               carry = 1'b0;
                end
                OP_ASR: begin
                    if (amt_below_w)   carry = src[dn_idx];
                    else               carry = msb;
                end
                default: begin
                    if (residue_zero)  carry = msb;
                    else               carry = src[dn_idx];
                end
            endcase
        end
    end

endmodule

// File: rtl/regshift_top.sv
module regshift_top
    import regshift_pkg::*;
#(
    parameter int DATA_W    = 32,
    parameter int AMT_REG_W = 32,
    parameter int AMT_SEL_W = 8
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic [DATA_W-1:0]    src_i,
    input  logic [AMT_REG_W-1:0] amt_i,
    input  logic [1:0]           kind_i,
    output logic [DATA_W-1:0]    res_o,
    output logic                 carry_o,
    output logic                 carry_vld_o
);

    localparam int SH_W = $clog2(DATA_W);

    typedef struct packed {
        logic [DATA_W-1:0] res;
        logic              carry;
        logic              carry_vld;
    } shift_out_t;

    shift_out_t out_d;
    shift_out_t out_q;

    shift_op_e         op;
    logic [SH_W-1:0]   sh_low;
    logic              amt_zero;
    logic              amt_below_w;
    logic              amt_at_w;
    logic              residue_zero;
    logic [DATA_W-1:0] shifted;
    logic              carry_nx;
    logic              carry_vld_nx;

    assign op = shift_op_e'(kind_i);

    regshift_decode #(
        .DATA_W    (DATA_W),
        .AMT_REG_W (AMT_REG_W),
        .AMT_SEL_W (AMT_SEL_W)
    ) decode_i (
        .amt_reg      (amt_i),
        .sh_low       (sh_low),
        .amt_zero     (amt_zero),
        .amt_below_w  (amt_below_w),
        .amt_at_w     (amt_at_w),
        .residue_zero (residue_zero)
    );

    regshift_barrel #(
        .DATA_W (DATA_W)
    ) barrel_i (
        .src     (src_i),
        .sh      (sh_low),
        .op      (op),
        .shifted (shifted)
    );

    regshift_carry #(
        .DATA_W (DATA_W)
    ) carry_i (
        .src          (src_i),
        .sh           (sh_low),
        .op           (op),
        .amt_zero     (amt_zero),
        .amt_below_w  (amt_below_w),
        .amt_at_w     (amt_at_w),
        .residue_zero (residue_zero),
        .carry        (carry_nx),
        .carry_vld    (carry_vld_nx)
    );

    always_comb begin
        out_d           = '0;
        out_d.carry     = carry_nx;
        out_d.carry_vld = carry_vld_nx;
        if (amt_zero) begin
            out_d.res = src_i;
        end else begin
            unique case (op)
                OP_LSL, OP_LSR: out_d.res = amt_below_w ? shifted : '0;
                OP_ASR:         out_d.res = amt_below_w ? shifted
                                          : {DATA_W{src_i[DATA_W-1]}};
                default:        out_d.res = shifted;
            endcase
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) out_q <= '0;
        else        out_q <= out_d;
    end

    assign res_o       = out_q.res;
    assign carry_o     = out_q.carry;
    assign carry_vld_o = out_q.carry_vld;

endmodule

// File: rtl/regshift_checker.sv
module regshift_checker #(
    parameter int DATA_W    = 32,
    parameter int AMT_REG_W = 32,
    parameter int AMT_SEL_W = 8
) (
    input logic                 clk,
    input logic                 rst_n,
    input logic [DATA_W-1:0]    src_i,
    input logic [AMT_REG_W-1:0] amt_i,
    input logic [1:0]           kind_i,
    input logic [DATA_W-1:0]    res_o,
    input logic                 carry_o,
    input logic                 carry_vld_o
);

    localparam int SH_W = $clog2(DATA_W);

    logic past_ok;
    always_ff @(posedge clk) begin
        if (!rst_n) past_ok <= 1'b0;
        else        past_ok <= 1'b1;
    end

    a_r2_zero_passes: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(amt_i[AMT_SEL_W-1:0] == '0)
        |-> res_o == $past(src_i) && !carry_vld_o);

    a_r8_nonzero_valid: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(amt_i[AMT_SEL_W-1:0] != '0) |-> carry_vld_o);

    a_r3_lsl_beyond: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(kind_i == 2'b00)
        && $past(amt_i[AMT_SEL_W-1:0] > AMT_SEL_W'(DATA_W))
        |-> res_o == '0 && !carry_o);

    a_r5_asr_fill: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(kind_i == 2'b10)
        && $past(amt_i[AMT_SEL_W-1:0] >= AMT_SEL_W'(DATA_W))
        |-> res_o == {DATA_W{$past(src_i[DATA_W-1])}}
            && carry_o == $past(src_i[DATA_W-1]));

    a_r7_ror_whole_turn: assert property (@(posedge clk) disable iff (!rst_n)
        past_ok && $past(kind_i == 2'b11)
        && $past(amt_i[SH_W-1:0] == '0)
        && $past(amt_i[AMT_SEL_W-1:0] != '0)
        |-> res_o == $past(src_i) && carry_o == $past(src_i[DATA_W-1]));

    a_r10_carry_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        !carry_vld_o |-> !carry_o);

endmodule

bind regshift_top regshift_checker #(
    .DATA_W    (DATA_W),
    .AMT_REG_W (AMT_REG_W),
    .AMT_SEL_W (AMT_SEL_W)
) checker_i (
    .clk         (clk),
    .rst_n       (rst_n),
    .src_i       (src_i),
    .amt_i       (amt_i),
    .kind_i      (kind_i),
    .res_o       (res_o),
    .carry_o     (carry_o),
    .carry_vld_o (carry_vld_o)
);

// File: tb/regshift_top_tb_top.sv
module regshift_top_tb_top;

    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] src_i = '0;
    logic [31:0] amt_i = '0;
    logic [1:0]  kind_i = '0;
    logic [31:0] res_o;
    logic        carry_o;
    logic        carry_vld_o;

    int n_checks = 0;
    int n_fails  = 0;

    always #(CLK_PERIOD/2) clk = ~clk;

    regshift_top dut_i (
        .clk         (clk),
        .rst_n       (rst_n),
        .src_i       (src_i),
        .amt_i       (amt_i),
        .kind_i      (kind_i),
        .res_o       (res_o),
        .carry_o     (carry_o),
        .carry_vld_o (carry_vld_o)
    );

    // Expected outputs derived from the requirement text.
    function automatic logic [33:0] model(input logic [31:0] v,
                                          input logic [31:0] a,
                                          input logic [1:0]  k);
        int          n;
        int          r;
        logic [31:0] res;
        logic        c;
        logic [63:0] dbl;
        n = int'(a[7:0]);
        if (n == 0) return {v, 1'b0, 1'b0};
        res = '0;
        c   = 1'b0;
        case (k)
            2'b00: begin
                if (n < 32) begin res = v << n; c = v[32-n]; end
                else if (n == 32) c = v[0];
            end
            2'b01: begin
                if (n < 32) begin res = v >> n; c = v[n-1]; end
                else if (n == 32) c = v[31];
            end
            2'b10: begin
                if (n < 32) begin
                    res = v >> n;
                    for (int b = 32 - n; b < 32; b++) res[b] = v[31];
                    c = v[n-1];
                end else begin
                    res = {32{v[31]}};
                    c = v[31];
                end
            end
            default: begin
                r = n % 32;
                if (r == 0) begin res = v; c = v[31]; end
                else begin
                    dbl = {v, v} >> r;
                    res = dbl[31:0];
                    c = v[r-1];
                end
            end
        endcase
        return {res, c, 1'b1};
    endfunction

    task automatic check(input string req, input logic [33:0] exp);
        n_checks++;
        if ({res_o, carry_o, carry_vld_o} !== exp) begin
            n_fails++;
            $display("FAIL %s: res=%h carry=%b vld=%b expected res=%h carry=%b vld=%b",
                     req, res_o, carry_o, carry_vld_o,
                     exp[33:2], exp[1], exp[0]);
        end
    endtask

    task automatic run_op(input string req, input logic [31:0] v,
                          input logic [31:0] a, input logic [1:0] k);
        @(negedge clk);
        src_i = v; amt_i = a; kind_i = k;
        @(negedge clk);
        check(req, model(v, a, k));
    endtask

    task automatic t_reset;
        src_i = 32'hFFFF_FFFF; amt_i = 32'd1; kind_i = 2'b00;
        @(negedge clk); @(negedge clk);
        check("R9 reset", 34'd0);
    endtask

    task automatic t_lsl;
        run_op("R3 lsl 1",   32'h8000_0001, 32'd1,  2'b00);
        run_op("R3 lsl 4",   32'h1234_5678, 32'd4,  2'b00);
        run_op("R3 lsl 31",  32'h0000_0002, 32'd31, 2'b00);
        run_op("R3 lsl 32",  32'h0000_0001, 32'd32, 2'b00);
        run_op("R3 lsl 33",  32'hFFFF_FFFF, 32'd33, 2'b00);
        run_op("R3 lsl 255", 32'hFFFF_FFFF, 32'd255, 2'b00);
    endtask

    task automatic t_lsr;
        run_op("R4 lsr 1",   32'h0000_0001, 32'd1,  2'b01);
        run_op("R4 lsr 8",   32'hDEAD_BEEF, 32'd8,  2'b01);
        run_op("R4 lsr 31",  32'h4000_0000, 32'd31, 2'b01);
        run_op("R4 lsr 32",  32'h8000_0000, 32'd32, 2'b01);
        run_op("R4 lsr 40",  32'hFFFF_FFFF, 32'd40, 2'b01);
    endtask

    task automatic t_asr;
        run_op("R5 asr neg 1",   32'h8000_0001, 32'd1,   2'b10);
        run_op("R5 asr neg 31",  32'hC000_0000, 32'd31,  2'b10);
        run_op("R5 asr pos 5",   32'h7000_0010, 32'd5,   2'b10);
        run_op("R5 asr neg 32",  32'h8000_0000, 32'd32,  2'b10);
        run_op("R5 asr pos 200", 32'h7FFF_FFFF, 32'd200, 2'b10);
    endtask

    task automatic t_ror;
        run_op("R6 ror 1",      32'h0000_0001, 32'd1,  2'b11);
        run_op("R6 ror 8",      32'h1234_5678, 32'd8,  2'b11);
        run_op("R6 ror 31",     32'h4000_0000, 32'd31, 2'b11);
        run_op("R6 ror 99",     32'h0000_0004, 32'd99, 2'b11);
        run_op("R7 ror 32",     32'h8000_0005, 32'd32, 2'b11);
        run_op("R7 ror 224",    32'h0000_0005, 32'd224, 2'b11);
    endtask

    task automatic t_zero;
        run_op("R2 zero lsl", 32'hA5A5_A5A5, 32'd0, 2'b00);
        run_op("R2 zero lsr", 32'h8000_0001, 32'd0, 2'b01);
        run_op("R2 zero asr", 32'h8000_0000, 32'd0, 2'b10);
        run_op("R2 zero ror", 32'hFFFF_FFFF, 32'd0, 2'b11);
    endtask

    task automatic t_upper;
        run_op("R1 upper only",  32'h8000_0003, 32'h1234_5600, 2'b11);
        run_op("R1 upper lsl 4", 32'h0F00_0001, 32'hFFFF_FF04, 2'b00);
        run_op("R1 upper asr 33",32'h8000_0000, 32'h0100_0021, 2'b10);
    endtask

    // Unchanged-word outcomes issued on consecutive cycles.
    task automatic t_same_word;
        @(negedge clk);
        src_i = 32'h8000_00F0; amt_i = 32'd64; kind_i = 2'b11;
        @(negedge clk);
        check("R7 R8 ror 64 beside zero", model(32'h8000_00F0, 32'd64, 2'b11));
        amt_i = 32'd0;
        @(negedge clk);
        check("R2 R10 zero beside ror 64", model(32'h8000_00F0, 32'd0, 2'b11));
        amt_i = 32'h0000_0020;
        @(negedge clk);
        check("R7 ror 32 beside zero", model(32'h8000_00F0, 32'd32, 2'b11));
        amt_i = 32'hABCD_0000;
        @(negedge clk);
        check("R1 R2 upper bits beside ror 32", model(32'h8000_00F0, 32'd0, 2'b11));
    endtask

    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fails++;
        $display("FAIL watchdog: run did not finish, expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

    initial begin
        t_reset();
        @(negedge clk);
        rst_n = 1'b1;
        t_lsl();
        t_lsr();
        t_asr();
        t_ror();
        t_zero();
        t_upper();
        t_same_word();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fails);
        $finish;
    end

endmodule